// File: doc/BRIEF.md
# Three-Mode Operand Address Generator

This block turns the three operand fields of a one-word, three-address instruction into effective addresses. Each field names an addressing mode: a direct address, an index register used as a base plus an 8-bit displacement, a pointer fetched from memory, or a fetched pointer that is then offset by an index base and displacement. The index registers come from the active program segment as one flat bank of eight words. Pointers are fetched through a single memory port with a one-cycle read latency.

An instruction is offered on a valid/ready request channel and is taken only while the block is idle. Fields are resolved in the order A, B, C. The three addresses then wait on a valid/ready result channel. Back-pressure on that channel freezes the result until it is taken. Each pointer used by an indirect field carries a 5-bit post-increment. The incremented pointer is written back to its memory word only after the instruction signals completion. The write-backs run one per cycle, in field order. A new request is accepted only after the last write-back.

Top module: `oag_top`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until that instruction has fully retired.
- R2: Each field is 29 bits: mode [28:27], index select [26:24], displacement [23:16], location [15:5], post-increment [4:0]. Field A sits at `req_ops[28:0]`, B at [57:29] and C at [86:58]. Mode 0 is direct. Its address is the 11-bit location zero-extended, so it is always below 2048. Index select, displacement and post-increment have no effect in this mode.
- R3: Mode 1 is indexed. The address is the selected index register plus the zero-extended displacement, modulo 2^16. Index register k is `ix_regs[16k+15:16k]`.
- R4: Mode 2 is indirect. The block issues exactly one memory read at the field's location. The word that returns is the address.
- R5: Mode 3 is indirect and indexed. The address is the fetched pointer plus the selected index register plus the displacement, modulo 2^16.
- R6: Fields resolve in the order A, B, C. A direct or indexed field takes one cycle. An indirect field takes two: a read cycle, then a capture cycle. `res_valid` rises 3 + (number of indirect fields) cycles after the accepting edge.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` and `res_ea` hold unchanged.
- R8: After the result is taken, pointer write-backs wait for `cmpl`. `cmpl` is sampled only in that waiting state and is ignored at any other time. Writes begin in the cycle after the edge that samples `cmpl`, one per cycle, in field order. Each write stores the fetched pointer plus the zero-extended post-increment, modulo 2^16, at the field's location.
- R9: An instruction with no indirect field returns to idle at the edge that takes the result, and it issues no write.
- R10: During and right after reset the block is idle. `req_ready` is high, and `res_valid`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_ops | input | 87 | Three packed operand fields, A in the low bits |
| ix_regs | input | 128 | Eight 16-bit index bases of the active segment |
| res_valid | output | 1 | Effective addresses available |
| res_ready | input | 1 | Consumer takes the addresses |
| res_ea | output | 48 | Effective addresses, A in the low 16 bits |
| cmpl | input | 1 | Instruction completed; releases write-backs |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address for read or write |
| mem_wdata | output | 16 | Write-back pointer value |
| mem_rdata | input | 16 | Read data, valid one cycle after the read strobe |

## Verification
The result is due 3 + n cycles after the accepting edge, where n is the number of indirect fields. The read for each indirect field is due in the first cycle of that field's slot. The first write-back is due in the cycle after the edge that samples `cmpl`. A behavioural model in the bench advances on every rising edge from the same inputs, using a queue of per-cycle read expectations and a queue of pending writes. It predicts every output each cycle, and each output is compared at the falling edge so that every register stage along the path has already settled. Completion pulses sent during resolution, and completion pulses sent to instructions with no pointers, are checked through the write strobe staying low.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FLD, ST_MEMW, ST_RES, ST_CMP, ST_WB
  } oag_state_e;

  localparam logic [1:0] AM_DIRECT   = 2'd0;
  localparam logic [1:0] AM_INDEXED  = 2'd1;
  localparam logic [1:0] AM_INDIRECT = 2'd2;
  localparam logic [1:0] AM_IND_IDX  = 2'd3;
endpackage

// File: rtl/oag_xr_mux.sv
module oag_xr_mux #(
  parameter int AW  = 16,
  parameter int NXR = 8,
  localparam int XSELW = $clog2(NXR)
) (
  input  logic [NXR*AW-1:0] bank,
  input  logic [XSELW-1:0]  sel,
  output logic [AW-1:0]     val
);
  logic [AW-1:0] words [NXR];

  for (genvar g = 0; g < NXR; g++) begin : g_unpack
    assign words[g] = bank[g*AW +: AW];
  end

  always_comb begin
    val = '0;
    for (int i = 0; i < NXR; i++)
      if (sel == XSELW'(i)) val = words[i];
  end
endmodule

// File: rtl/oag_ea_calc.sv
module oag_ea_calc
  import oag_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DISPW = 8,
  parameter int LOCW  = 11
) (
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    xval,
  input  logic [DISPW-1:0] disp,
  input  logic [LOCW-1:0]  loc,
  input  logic [AW-1:0]    ptr,
  output logic [AW-1:0]    ea
);
  always_comb begin
    case (mode)
      AM_DIRECT:   ea = AW'(loc);
      AM_INDEXED:  ea = xval + AW'(disp);
      AM_INDIRECT: ea = ptr;
      default:     ea = ptr + xval + AW'(disp);
    endcase
  end
endmodule

// File: rtl/oag_pend_pick.sv
module oag_pend_pick #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic [IW-1:0] idx,
  output logic          last
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) idx = IW'(i);
  end

  assign last = ((pend & (pend - 1'b1)) == '0);
endmodule

// File: rtl/oag_top.sv
module oag_top
  import oag_pkg::*;
#(
  parameter int AW    = 16,
  parameter int NXR   = 8,
  parameter int DISPW = 8,
  parameter int LOCW  = 11,
  parameter int PINCW = 5,
  parameter int NOPS  = 3,
  localparam int XSELW = $clog2(NXR),
  localparam int FW    = 2 + XSELW + DISPW + LOCW + PINCW,
  localparam int OPW   = (NOPS > 1) ? $clog2(NOPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [NOPS*FW-1:0] req_ops,
  input  logic [NXR*AW-1:0]  ix_regs,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [NOPS*AW-1:0] res_ea,
  input  logic               cmpl,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [AW-1:0]      mem_addr,
  output logic [AW-1:0]      mem_wdata,
  input  logic [AW-1:0]      mem_rdata
);
  localparam int LOC_LSB  = PINCW;
  localparam int DISP_LSB = LOC_LSB + LOCW;
  localparam int XS_LSB   = DISP_LSB + DISPW;
  localparam int MODE_LSB = XS_LSB + XSELW;

  oag_state_e      st_q;
  logic [FW-1:0]   op_q  [NOPS];
  logic [AW-1:0]   ea_q  [NOPS];
  logic [AW-1:0]   ptr_q [NOPS];
  logic [NOPS-1:0] pend_q;
  logic [OPW-1:0]  idx_q;

  logic [1:0]       cur_mode;
  logic [XSELW-1:0] cur_xs;
  logic [DISPW-1:0] cur_disp;
  logic [LOCW-1:0]  cur_loc;
  logic [AW-1:0]    cur_x, ea_new;
  logic             last_op, field_done;
  logic [OPW-1:0]   wb_idx;
  logic             wb_last;
  logic [LOCW-1:0]  wb_loc;
  logic [PINCW-1:0] wb_pinc;

  assign cur_mode = op_q[idx_q][MODE_LSB +: 2];
  assign cur_xs   = op_q[idx_q][XS_LSB +: XSELW];
  assign cur_disp = op_q[idx_q][DISP_LSB +: DISPW];
  assign cur_loc  = op_q[idx_q][LOC_LSB +: LOCW];
  assign wb_loc   = op_q[wb_idx][LOC_LSB +: LOCW];
  assign wb_pinc  = op_q[wb_idx][0 +: PINCW];

  oag_xr_mux #(.AW(AW), .NXR(NXR)) u_xmux (
    .bank(ix_regs), .sel(cur_xs), .val(cur_x)
  );

  oag_ea_calc #(.AW(AW), .DISPW(DISPW), .LOCW(LOCW)) u_calc (
    .mode(cur_mode), .xval(cur_x), .disp(cur_disp), .loc(cur_loc),
    .ptr(mem_rdata), .ea(ea_new)
  );

  oag_pend_pick #(.N(NOPS)) u_pick (
    .pend(pend_q), .idx(wb_idx), .last(wb_last)
  );

  assign last_op    = (idx_q == OPW'(NOPS - 1));
  assign field_done = (st_q == ST_MEMW) || (st_q == ST_FLD && !cur_mode[1]);

  assign req_ready = (st_q == ST_IDLE);
  assign res_valid = (st_q == ST_RES);
  assign mem_rd_en = (st_q == ST_FLD) && cur_mode[1];
  assign mem_wr_en = (st_q == ST_WB);
  assign mem_wdata = ptr_q[wb_idx] + AW'(wb_pinc);

  always_comb begin
    mem_addr = '0;
    if (mem_rd_en)      mem_addr = AW'(cur_loc);
    else if (mem_wr_en) mem_addr = AW'(wb_loc);
  end

  for (genvar k = 0; k < NOPS; k++) begin : g_res
    assign res_ea[k*AW +: AW] = ea_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      pend_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid) begin
          idx_q  <= '0;
          pend_q <= '0;
          st_q   <= ST_FLD;
        end
        ST_FLD, ST_MEMW: begin
          if (st_q == ST_MEMW) pend_q[idx_q] <= 1'b1;
          if (st_q == ST_FLD && cur_mode[1]) begin
            st_q <= ST_MEMW;
          end else if (last_op) begin
            st_q <= ST_RES;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_FLD;
          end
        end
        ST_RES: if (res_ready) st_q <= (|pend_q) ? ST_CMP : ST_IDLE;
        ST_CMP: if (cmpl) st_q <= ST_WB;
        ST_WB: begin
          pend_q[wb_idx] <= 1'b0;
          if (wb_last) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_q == ST_IDLE && req_valid)
      for (int k = 0; k < NOPS; k++) op_q[k] <= req_ops[k*FW +: FW];
    if (field_done) ea_q[idx_q] <= ea_new;
    if (st_q == ST_MEMW) ptr_q[idx_q] <= mem_rdata;
  end
endmodule

// File: rtl/oag_checker.sv
module oag_checker #(
  parameter int AW   = 16,
  parameter int NOPS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               res_valid,
  input logic               res_ready,
  input logic [NOPS*AW-1:0] res_ea,
  input logic               cmpl,
  input logic               mem_rd_en,
  input logic               mem_wr_en
);
  p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_port_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_read_in_resolve_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (!req_ready && !res_valid));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ea)));

  p_write_after_cmpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !$past(mem_wr_en)) |-> $past(cmpl));

  p_no_write_in_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_wr_en);
endmodule

bind oag_top oag_checker #(.AW(AW), .NOPS(NOPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_ea(res_ea),
  .cmpl(cmpl), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en)
);

// File: tb/oag_top_tb.sv
module oag_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NOPS = 3;
  localparam int FW = 29;

  logic clk, rst_n, req_valid, req_ready, res_valid, res_ready, cmpl;
  logic mem_rd_en, mem_wr_en;
  logic [NOPS*FW-1:0] req_ops;
  logic [8*AW-1:0] ix_regs;
  logic [NOPS*AW-1:0] res_ea;
  logic [AW-1:0] mem_addr, mem_wdata, mem_rdata;

  int compared = 0, mismatched = 0;
  bit fin = 0;

  oag_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ops(req_ops), .ix_regs(ix_regs), .res_valid(res_valid),
    .res_ready(res_ready), .res_ea(res_ea), .cmpl(cmpl),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [AW-1:0] init_val(int i);
    if (i == 100) return 16'hFFFF;
    if (i == 200) return 16'hFFF8;
    return 16'(i * 997 + 16'h0123);
  endfunction

  logic [AW-1:0] mem [0:2047];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= init_val(i);
      mem_rdata <= '0;
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[10:0]];
      if (mem_wr_en) mem[mem_addr[10:0]] <= mem_wdata;
    end
  end

  // Behavioural reference model
  int ph;
  logic [16:0] rq[$];
  logic [31:0] wq[$];
  logic [AW-1:0] m_ea [NOPS];
  string m_tag [NOPS];
  string rdy_tag;
  bit m_anyind, hold_prev;

  task automatic model_accept();
    m_anyind = 0;
    for (int k = 0; k < NOPS; k++) begin
      logic [FW-1:0] op;
      logic [1:0] md;
      logic [2:0] xs;
      logic [7:0] d;
      logic [10:0] loc;
      logic [4:0] pi;
      logic [AW-1:0] x, p;
      op = req_ops[k*FW +: FW];
      md = op[28:27]; xs = op[26:24]; d = op[23:16]; loc = op[15:5]; pi = op[4:0];
      x = ix_regs[xs*AW +: AW];
      p = mem[loc];
      case (md)
        2'd0: begin m_ea[k] = {5'd0, loc}; m_tag[k] = "R2"; rq.push_back(17'd0); end
        2'd1: begin m_ea[k] = x + {8'd0, d}; m_tag[k] = "R3"; rq.push_back(17'd0); end
        default: begin
          m_ea[k] = (md == 2'd2) ? p : p + x + {8'd0, d};
          m_tag[k] = (md == 2'd2) ? "R4" : "R5";
          rq.push_back({1'b1, 5'd0, loc});
          rq.push_back(17'd0);
          wq.push_back({5'd0, loc, p + {11'd0, pi}});
          m_anyind = 1;
        end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; rq.delete(); wq.delete(); rdy_tag = "R10"; hold_prev = 0;
    end else begin
      case (ph)
        0: if (req_valid) begin model_accept(); ph = 1; rdy_tag = "R1"; end
        1: begin void'(rq.pop_front()); hold_prev = 0; if (rq.size() == 0) ph = 2; end
        2: if (res_ready) begin
             ph = m_anyind ? 3 : 0;
             rdy_tag = m_anyind ? "R1" : "R9";
           end else hold_prev = 1;
        3: if (cmpl) ph = 4;
        default: begin
          void'(wq.pop_front());
          if (wq.size() == 0) begin ph = 0; rdy_tag = "R8"; end
        end
      endcase
    end
  end

  task automatic check(input logic [31:0] got, input logic [31:0] exp,
                       input string tag, input string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit rd_exp, wr_exp;
      check(32'(req_ready), 32'(ph == 0), rdy_tag, "req_ready");
      check(32'(res_valid), 32'(ph == 2), "R6", "res_valid timing");
      if (ph == 2)
        for (int k = 0; k < NOPS; k++)
          check(32'(res_ea[k*AW +: AW]), 32'(m_ea[k]), hold_prev ? "R7" : m_tag[k], "res_ea");
      rd_exp = (ph == 1) && rq[0][16];
      check(32'(mem_rd_en), 32'(rd_exp), "R6", "mem_rd_en order");
      if (rd_exp) check(32'(mem_addr), {16'd0, 5'd0, rq[0][10:0]}, "R4", "read address");
      wr_exp = (ph == 4);
      check(32'(mem_wr_en), 32'(wr_exp), "R8", "mem_wr_en");
      if (wr_exp) begin
        check(32'(mem_addr), {16'd0, wq[0][31:16]}, "R8", "write address");
        check(32'(mem_wdata), {16'd0, wq[0][15:0]}, "R8", "write data");
      end
    end
  end

  function automatic logic [FW-1:0] mk(logic [1:0] md, logic [2:0] xs, logic [7:0] d,
                                       logic [10:0] loc, logic [4:0] pi);
    return {md, xs, d, loc, pi};
  endfunction

  task automatic run_instr(input logic [NOPS*FW-1:0] ops, input logic [8*AW-1:0] xb,
                           input int hold, input int cdly);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ops = ops; ix_regs = xb; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    cmpl = 1;               // ignored while fields resolve (R8)
    @(negedge clk);
    cmpl = 0;
    while (!res_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    repeat (cdly) @(negedge clk);
    cmpl = 1;               // releases write-backs, or ignored when idle (R9)
    @(negedge clk);
    cmpl = 0;
    while (!req_ready) @(negedge clk);
  endtask

  logic [8*AW-1:0] xb1;

  initial begin
    rst_n = 0; req_valid = 0; res_ready = 0; cmpl = 0; req_ops = '0; ix_regs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(32'(req_ready), 32'd1, "R10", "reset req_ready");
    check(32'(res_valid), 32'd0, "R10", "reset res_valid");
    check(32'(mem_rd_en), 32'd0, "R10", "reset mem_rd_en");
    check(32'(mem_wr_en), 32'd0, "R10", "reset mem_wr_en");
    rst_n = 1;

    xb1 = '0;
    xb1[0*AW +: AW] = 16'h1000;
    xb1[3*AW +: AW] = 16'h0200;
    xb1[7*AW +: AW] = 16'hFFF0;

    // R2: direct, junk in unused fields
    run_instr({mk(2'd0, 3'd7, 8'hAA, 11'd5, 5'd31), mk(2'd0, 3'd0, 8'd0, 11'd2047, 5'd0),
               mk(2'd0, 3'd0, 8'd0, 11'd0, 5'd0)}, xb1, 0, 0);
    // R3: indexed incl. wrap
    run_instr({mk(2'd1, 3'd3, 8'd0, 11'd9, 5'd0), mk(2'd1, 3'd7, 8'h20, 11'd0, 5'd0),
               mk(2'd1, 3'd0, 8'hFF, 11'd0, 5'd0)}, xb1, 2, 0);
    // R4, R8: indirect all, post-increment wrap at 100
    run_instr({mk(2'd2, 3'd0, 8'd0, 11'd2047, 5'd0), mk(2'd2, 3'd0, 8'd0, 11'd100, 5'd31),
               mk(2'd2, 3'd0, 8'd0, 11'd10, 5'd3)}, xb1, 3, 4);
    // R5: indirect indexed with wrap, mixed with direct
    run_instr({mk(2'd0, 3'd0, 8'd0, 11'd1234, 5'd0), mk(2'd3, 3'd3, 8'h01, 11'd11, 5'd1),
               mk(2'd3, 3'd7, 8'h30, 11'd200, 5'd7)}, xb1, 1, 2);
    // R8: same pointer word used twice, writes in field order
    run_instr({mk(2'd2, 3'd0, 8'd0, 11'd300, 5'd2), mk(2'd1, 3'd7, 8'd0, 11'd0, 5'd0),
               mk(2'd2, 3'd0, 8'd0, 11'd300, 5'd1)}, xb1, 0, 0);
    // R4: re-read the updated pointers
    run_instr({mk(2'd2, 3'd0, 8'd0, 11'd300, 5'd0), mk(2'd2, 3'd0, 8'd0, 11'd100, 5'd0),
               mk(2'd3, 3'd0, 8'd4, 11'd10, 5'd0)}, xb1, 0, 1);
    // R6: single indirect in middle slot
    run_instr({mk(2'd1, 3'd0, 8'd1, 11'd0, 5'd0), mk(2'd2, 3'd0, 8'd0, 11'd0, 5'd9),
               mk(2'd0, 3'd0, 8'd0, 11'd7, 5'd0)}, xb1, 5, 3);

    repeat (3) @(negedge clk);
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual hung expected retire");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule